// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block is the per-pin slice of a general-purpose I/O controller. A small register port carries four registers: pad control (function select, drive strength code, pull mode, output enable), pin data (output value and the synchronized input), interrupt configuration (detection mode, polarity, raw-status enable, request enable, routing target) and the latched interrupt status. The pad-facing outputs carry the control fields. The interrupt outputs carry a gated request, the routing target and the raw status bit, so that a multi-pin summary tree outside the block can collect them.

The pin input passes through a chain of synchronizer flops. The block then compares the current synchronized sample with the sample one cycle older, and so detects rising edges, falling edges, both edges, or an active level. A build parameter fixes which written value of the status bit acknowledges an event.

Register map (word select `reg_addr`): 0 = pad control, 1 = pin data, 2 = interrupt configuration, 3 = status. Pad control bits: [2:0] function, [5:3] drive code, [7:6] pull, [8] output enable. Pin data bits: [0] synchronized input (read only), [1] output value. Interrupt configuration bits: [0] request enable, [2:1] detection mode, [3] polarity, [4] raw-status enable, [7:5] target. Status bits: [0] event latched. Unused read bits return 0.

Top module: `gpin_intr_pin`

## Requirements
- R1: After synchronous reset, all four registers read 0, `pin_oe`, `pin_out`, `irq_req` and `irq_status` are 0, and `drive_ma` is 2.
- R2: A write to pad control at `reg_addr` 0 is read back unchanged and appears on `func_sel` (bits [2:0]) and `pull_mode` (bits [7:6]: 0 none, 1 pull-down, 2 keeper, 3 pull-up).
- R3: `pin_oe` follows control bit 8, and `pin_out` equals the pin-data output bit [1] when `pin_oe` is 1 and is 0 otherwise.
- R4: Pin-data bit [0] shows `pin_in` after exactly two clock edges of synchronization, and not after one.
- R5: Detection mode field bits [2:1]: 0 level, 1 rising, 2 falling, 3 both edges. Status latches only on a matching transition of the synchronized input.
- R6: In level mode, polarity 1 makes a high input active and polarity 0 makes a low input active.
- R7: In the edge modes, the polarity bit has no effect on which edges latch status.
- R8: With raw-status enable (bit 4) at 0, no event latches status. Turning the enable on while the input is steady creates no event.
- R9: `irq_req` is `irq_status` gated by request enable bit 0. The enable does not stop status from latching.
- R10: `irq_target` carries configuration bits [7:5] and changes only on a configuration write.
- R11: Writing status bit 0 with value equal to parameter ACK_HIGH clears status; writing the other value leaves it set.
- R12: In level mode, status stays 1 through an acknowledge while the level is active.
- R13: A qualifying edge in the same cycle as an acknowledge leaves status at 1.
- R14: `drive_ma` equals (drive code + 1) * 2, spanning 2 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for `reg_addr` (combinational) |
| pin_in | input | 1 | Asynchronous pad input |
| pin_out | output | 1 | Output value to pad |
| pin_oe | output | 1 | Pad output enable |
| func_sel | output | 3 | Function select to pad mux |
| pull_mode | output | 2 | Pull mode to pad |
| drive_ma | output | 5 | Decoded drive strength in mA |
| irq_req | output | 1 | Enabled interrupt request |
| irq_target | output | 3 | Processor routing target |
| irq_status | output | 1 | Latched status for the summary tree |

## Verification
The bench builds two copies side by side on shared inputs: one with ACK_HIGH = 1 and one with ACK_HIGH = 0, both with the default two-stage synchronizer. Each status write therefore acknowledges one copy and has no effect on the other. This checks both acknowledge conventions in the same cycle, and checks that the wrong value has no effect. The set-versus-acknowledge collision is timed to the exact edge on which the synchronized input first differs from its previous sample.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

    localparam int REG_W  = 9;
    localparam int CTRL_W = 9;
    localparam int ICFG_W = 8;
    localparam int MA_W   = 5;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_IO   = 2'd1,
        REG_ICFG = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_RISE  = 2'd1,
        DET_FALL  = 2'd2,
        DET_BOTH  = 2'd3
    } det_mode_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_KEEP = 2'd2,
        PULL_UP   = 2'd3
    } pull_e;

    // Packed MSB first: oe[8], pull[7:6], drive[5:3], func[2:0]
    typedef struct packed {
        logic       oe;
        pull_e      pull;
        logic [2:0] drive;
        logic [2:0] func;
    } ctrl_t;

    // Packed MSB first: target[7:5], raw_en[4], pol[3], mode[2:1], irq_en[0]
    typedef struct packed {
        logic [2:0] target;
        logic       raw_en;
        logic       pol;
        det_mode_e  mode;
        logic       irq_en;
    } icfg_t;

    function automatic logic [MA_W-1:0] drive_to_ma(input logic [2:0] code);
        logic [MA_W-1:0] wide;
        wide = {{(MA_W-3){1'b0}}, code} + {{(MA_W-1){1'b0}}, 1'b1};
        return wide << 1;
    endfunction

    function automatic logic event_match(input det_mode_e mode, input logic pol,
                                         input logic cur, input logic prev);
        logic m;
        unique case (mode)
            DET_LEVEL: m = (cur == pol);
            DET_RISE:  m = cur & ~prev;
            DET_FALL:  m = ~cur & prev;
            DET_BOTH:  m = cur ^ prev;
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[LAST];
endmodule

// File: rtl/gpin_regs.sv
module gpin_regs
    import gpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             in_sync,
    input  logic             status,
    output ctrl_t            ctrl,
    output icfg_t            icfg,
    output logic             out_val,
    output logic             stat_wr,
    output logic [REG_W-1:0] rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            icfg    <= '0;
            out_val <= 1'b0;
        end else if (we) begin
            unique case (sel)
                REG_CTRL: ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
                REG_IO:   out_val <= wdata[1];
                REG_ICFG: icfg    <= icfg_t'(wdata[ICFG_W-1:0]);
                default:  ;
            endcase
        end
    end

    assign stat_wr = we && (sel == REG_STAT);

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CTRL: rdata[CTRL_W-1:0] = ctrl;
            REG_IO:   rdata[1:0]        = {out_val, in_sync};
            REG_ICFG: rdata[ICFG_W-1:0] = icfg;
            REG_STAT: rdata[0]          = status;
            default:  rdata             = '0;
        endcase
    end
endmodule

// File: rtl/gpin_detect.sv
module gpin_detect
    import gpin_pkg::*;
#(
    parameter bit ACK_HIGH = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  s_cur,
    input  icfg_t cfg,
    input  logic  stat_wr,
    input  logic  ack_bit,
    output logic  hit,
    output logic  status
);
    logic s_prev;
    logic ack;

    always_ff @(posedge clk) begin
        if (rst) s_prev <= 1'b0;
        else     s_prev <= s_cur;
    end

    // The previous sample always tracks, so turning raw_en on sees no stale edge.
    assign hit = cfg.raw_en && event_match(cfg.mode, cfg.pol, s_cur, s_prev);
    assign ack = stat_wr && (ack_bit == ACK_HIGH);

    always_ff @(posedge clk) begin
        if (rst)      status <= 1'b0;
        else if (hit) status <= 1'b1;
        else if (ack) status <= 1'b0;
    end
endmodule

// File: rtl/gpin_intr_pin.sv
module gpin_intr_pin
    import gpin_pkg::*;
#(
    parameter bit ACK_HIGH    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic [2:0]       func_sel,
    output logic [1:0]       pull_mode,
    output logic [MA_W-1:0]  drive_ma,
    output logic             irq_req,
    output logic [2:0]       irq_target,
    output logic             irq_status
);
    ctrl_t ctrl_q;
    icfg_t icfg_q;
    logic  out_q;
    logic  in_s;
    logic  stat_wr;
    logic  hit;
    logic  status_q;

    gpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (in_s)
    );

    gpin_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .in_sync (in_s),
        .status  (status_q),
        .ctrl    (ctrl_q),
        .icfg    (icfg_q),
        .out_val (out_q),
        .stat_wr (stat_wr),
        .rdata   (reg_rdata)
    );

    gpin_detect #(.ACK_HIGH(ACK_HIGH)) u_det (
        .clk     (clk),
        .rst     (rst),
        .s_cur   (in_s),
        .cfg     (icfg_q),
        .stat_wr (stat_wr),
        .ack_bit (reg_wdata[0]),
        .hit     (hit),
        .status  (status_q)
    );

    assign pin_oe     = ctrl_q.oe;
    assign pin_out    = ctrl_q.oe & out_q;
    assign func_sel   = ctrl_q.func;
    assign pull_mode  = ctrl_q.pull;
    assign drive_ma   = drive_to_ma(ctrl_q.drive);
    assign irq_req    = status_q & icfg_q.irq_en;
    assign irq_target = icfg_q.target;
    assign irq_status = status_q;
endmodule

// File: rtl/gpin_intr_pin_chk.sv
module gpin_intr_pin_chk
    import gpin_pkg::*;
#(
    parameter bit ACK_HIGH = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             pin_in,
    input logic             in_s,
    input logic             hit,
    input icfg_t            cfg,
    input logic             pin_out,
    input logic             pin_oe,
    input logic [2:0]       irq_target,
    input logic             irq_status
);
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R13: an event always leaves status set, even against an acknowledge
    a_r13_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq_status);

    // R8: with raw enable off a clear status stays clear
    a_r8_raw_off_holds: assert property (@(posedge clk) disable iff (rst)
        (!cfg.raw_en && !irq_status) |=> !irq_status);

    // R11: a matching acknowledge without a new event clears status
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd3 && reg_wdata[0] == ACK_HIGH && !hit) |=> !irq_status);

    // R10: target moves only on a configuration write
    a_r10_target_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == 2'd2) |=> $stable(irq_target));

    // R3: the pad is never driven high while output is disabled
    a_r3_out_needs_oe: assert property (@(posedge clk) disable iff (rst)
        pin_out |-> pin_oe);

    // R4: synchronized input lags the pad by two edges
    a_r4_sync_lag: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (in_s == $past(pin_in, 2)));
endmodule

bind gpin_intr_pin gpin_intr_pin_chk #(.ACK_HIGH(ACK_HIGH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pin_in     (pin_in),
    .in_s       (in_s),
    .hit        (hit),
    .cfg        (icfg_q),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq_target (irq_target),
    .irq_status (irq_status)
);

// File: tb/sim_gpin_intr_pin.sv
module sim_gpin_intr_pin;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [8:0] reg_wdata = '0;
    logic       pin_in = 1'b0;

    logic [8:0] rd0, rd1;
    logic       po0, po1, oe0, oe1, rq0, rq1, st0, st1;
    logic [2:0] fs0, fs1, tg0, tg1;
    logic [1:0] pm0, pm1;
    logic [4:0] ma0, ma1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpin_intr_pin #(.ACK_HIGH(1'b1)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd0), .pin_in(pin_in),
        .pin_out(po0), .pin_oe(oe0), .func_sel(fs0), .pull_mode(pm0),
        .drive_ma(ma0), .irq_req(rq0), .irq_target(tg0), .irq_status(st0));

    gpin_intr_pin #(.ACK_HIGH(1'b0)) u1 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .pin_in(pin_in),
        .pin_out(po1), .pin_oe(oe1), .func_sel(fs1), .pull_mode(pm1),
        .drive_ma(ma1), .irq_req(rq1), .irq_target(tg1), .irq_status(st1));

    // {mode[1:0], pol, pin_start, pin_end, expected status}
    localparam logic [5:0] VEC [13] = '{
        6'b00_1_0_1_1, 6'b00_1_0_0_0, 6'b00_0_1_0_1, 6'b00_0_1_1_0,
        6'b01_1_0_1_1, 6'b01_0_0_1_1, 6'b01_1_1_0_0,
        6'b10_1_1_0_1, 6'b10_0_1_0_1, 6'b10_1_0_1_0,
        6'b11_1_0_1_1, 6'b11_1_1_0_1, 6'b11_1_1_1_0
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic clear_both();
        wr(2'd3, 9'd1);
        wr(2'd3, 9'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0]);
            chk("R1 reg readback", rd0, 0);
        end
        chk("R1 pin_oe", oe0, 0);
        chk("R1 pin_out", po0, 0);
        chk("R1 irq_req", rq0, 0);
        chk("R1 irq_status", st1, 0);
        chk("R1 drive_ma", ma0, 2);

        // R2 / R14 control register
        wr(2'd0, 9'b0_11_101_110);
        rd(2'd0);
        chk("R2 ctrl readback", rd0, 9'h0EE);
        chk("R2 func_sel", fs0, 6);
        chk("R2 pull_mode", pm0, 3);
        chk("R14 drive code 5", ma0, 12);
        wr(2'd0, 9'b0_01_111_001);
        chk("R14 drive code 7", ma0, 16);
        chk("R2 pull down", pm0, 1);

        // R3 output gating
        wr(2'd1, 9'b10);
        chk("R3 out masked", po0, 0);
        wr(2'd0, 9'b1_00_000_000);
        chk("R3 oe", oe0, 1);
        chk("R3 out driven", po0, 1);
        wr(2'd1, 9'b00);
        chk("R3 out low", po0, 0);

        // R4 synchronizer latency
        rd(2'd1);
        pin_in = 1'b1;
        cyc(1); #1;
        chk("R4 after one edge", rd0[0], 0);
        cyc(1); #1;
        chk("R4 after two edges", rd0[0], 1);
        pin_in = 1'b0;
        cyc(4);

        // R5 R6 R7 detection table
        foreach (VEC[i]) begin
            pin_in = VEC[i][2];
            cyc(4);
            wr(2'd2, {3'd0, 1'b1, VEC[i][3], VEC[i][5:4], 1'b1});
            clear_both();
            pin_in = VEC[i][1];
            cyc(4);
            chk("R5 R6 R7 status u0", st0, VEC[i][0]);
            chk("R5 R6 R7 status u1", st1, VEC[i][0]);
            chk("R9 req follows", rq0, VEC[i][0]);
        end

        // R8 raw enable off, then on with steady input
        pin_in = 1'b0;
        cyc(4);
        wr(2'd2, {3'd0, 1'b0, 1'b1, 2'd1, 1'b1});
        clear_both();
        pin_in = 1'b1;
        cyc(4);
        chk("R8 raw off no latch", st0, 0);
        wr(2'd2, {3'd0, 1'b1, 1'b1, 2'd1, 1'b1});
        cyc(4);
        chk("R8 enable no spurious", st0, 0);

        // R9 request enable gates only the request
        pin_in = 1'b0;
        cyc(4);
        wr(2'd2, {3'd0, 1'b1, 1'b1, 2'd1, 1'b0});
        clear_both();
        pin_in = 1'b1;
        cyc(4);
        chk("R9 status latched", st0, 1);
        chk("R9 request masked", rq0, 0);
        wr(2'd2, {3'd0, 1'b1, 1'b1, 2'd1, 1'b1});
        chk("R9 request on", rq0, 1);

        // R10 target
        wr(2'd2, {3'd5, 1'b1, 1'b1, 2'd1, 1'b1});
        chk("R10 target", tg0, 5);
        rd(2'd2);
        chk("R10 target readback", rd0[7:5], 5);

        // R11 acknowledge polarity (both set from R9)
        wr(2'd3, 9'd0);
        chk("R11 write0 keeps u0", st0, 1);
        chk("R11 write0 clears u1", st1, 0);
        wr(2'd3, 9'd1);
        chk("R11 write1 clears u0", st0, 0);
        rd(2'd3);
        chk("R11 status read u0", rd0[0], 0);

        // R12 level persists through acknowledge (pin is 1)
        wr(2'd2, {3'd0, 1'b1, 1'b1, 2'd0, 1'b1});
        cyc(1);
        chk("R12 level set", st0, 1);
        wr(2'd3, 9'd1);
        chk("R12 after ack u0", st0, 1);
        wr(2'd3, 9'd0);
        chk("R12 after ack u1", st1, 1);

        // R13 edge coincides with acknowledge
        pin_in = 1'b0;
        wr(2'd2, {3'd0, 1'b1, 1'b1, 2'd1, 1'b1});
        cyc(4);
        clear_both();
        chk("R13 cleared first", st0, 0);
        pin_in = 1'b1;
        cyc(2);
        wr(2'd3, 9'd1);
        chk("R13 set wins", st0, 1);
        wr(2'd3, 9'd1);
        chk("R13 later ack clears", st0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule